// File: doc/BRIEF.md
# Multi-Port Host Packet Mailbox

This block sits on the device side of a host link. It gives the host a 32-bit memory-mapped window with two spaces. The first is a 128-byte register window. The second is a packet RAM that holds one receive buffer and one transmit buffer for each line port, up to four ports. Ports at or above the `NUM_PORTS` parameter (default 2) are inactive.

Every packet begins with an 8-byte little-endian header. Word 0 carries the payload length in bits 15:0 and the path identifier in bits 31:16. Word 1 carries the channel identifier in bits 15:0 and the packet kind in bits 31:16. The length counts payload bytes only and never includes the header.

Host and device pass buffer ownership through one shared flags word:

- **Transmit direction.** The host fills a port's transmit buffer, then sets that port's busy bit. The device streams the packet out on the port's transmit stream and drops the bit when it is done.
- **Receive direction.** The device writes an incoming stream packet into the port's receive buffer and raises a ready bit. The host reads the packet and writes 1 to that bit to hand the buffer back.

A level interrupt reports completed hand-overs to the host.

Top module: `pkt_mailbox`

## Requirements
- R1: The register window is addressed by byte address bits 6:2 and has four registers:
  - flags at 0x7C;
  - interrupt enable at 0x78 (bit 0);
  - version at 0x74, which reads {major[31:24], minor[23:16], build[15:0]} and ignores writes;
  - interrupt clear at 0x70.

  Every other offset reads 0. Read data appears on `hst_rdata` with `hst_rvalid` one cycle after the read request.
- R2: Writing 1 to flags bit n (n < NUM_PORTS) sets port n's transmit-busy bit. Writing 0 leaves it unchanged. Only the device's completion clears it. Flag bits of inactive ports always read 0.
- R3: Writing 1 to flags bit 4+n clears port n's receive-ready bit. Writing 0 leaves it unchanged.
- R4: In the packet space, port n owns bytes n×2×BUF_BYTES upward. With the default BUF_BYTES of 4096, this is 8 KB per port: the receive buffer first, then the transmit buffer. Words written by the host read back unchanged. Slices of inactive ports ignore writes and read 0.
- R5: Once port n is busy, the device streams 2 + ceil(len/4) words from its transmit buffer, starting at word 0. `txs_last` marks the final word. Valid, data and last hold steady while ready is low. The busy bit then clears.
- R6: A transmit header whose length exceeds BUF_BYTES−8 streams no words, and the busy bit clears.
- R7: While its receive-ready bit is clear, a port accepts stream words into its receive buffer from word 0 upward. The final word sets bit 4+n. While that bit is set, `rxs_ready` for the port is low.
- R8: A received packet is discarded and its ready bit stays clear in two cases: the header length exceeds BUF_BYTES−8, or the packet runs past BUF_BYTES/4 words. The next packet is then accepted normally.
- R9: A rising receive-ready bit or a falling transmit-busy bit latches a pending interrupt. `irq` equals pending AND enable. Disabling the interrupt masks it but keeps it pending.
- R10: Any write to the clear register drops the pending interrupt. An event arriving afterwards latches it again.
- R11: After reset, all flags read 0, the interrupt enable is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access strobe |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_space | input | 1 | 0 = register window, 1 = packet RAM |
| hst_addr | input | 15 | Byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| hst_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Level interrupt to the host |
| txs_valid | output | NUM_PORTS | Transmit stream valid, per port |
| txs_ready | input | NUM_PORTS | Transmit stream ready, per port |
| txs_data | output | NUM_PORTS×32 | Transmit stream word, per port |
| txs_last | output | NUM_PORTS | Final word of the transmit packet |
| rxs_valid | input | NUM_PORTS | Receive stream valid, per port |
| rxs_ready | output | NUM_PORTS | Receive stream ready, per port |
| rxs_data | input | NUM_PORTS×32 | Receive stream word, per port |
| rxs_last | input | NUM_PORTS | Final word of the receive packet |

## Verification
The assertions check the following on every cycle:
- stream words stay stable while a transmit stream is stalled;
- a transmit stream is never valid without its busy bit;
- a receive port never shows ready while its buffer is held;
- a busy bit falls only after a completion;
- a raised interrupt persists until a clear or an enable write;
- read data arrives one cycle after each read.

Only the bench scenarios can show word counts against header lengths, oversize rejection in both directions, buffer contents at their addresses, masking with a retained pending interrupt, and the ignored writes to flags and version.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MAX_PORTS    = 4;
    localparam int unsigned HDR_BYTES    = 8;
    localparam int unsigned FLAG_RX_BASE = 4;

    // Register word offsets (byte address bits 6:2)
    localparam logic [4:0] OFF_ICLR  = 5'h1C;
    localparam logic [4:0] OFF_VER   = 5'h1D;
    localparam logic [4:0] OFF_IEN   = 5'h1E;
    localparam logic [4:0] OFF_FLAGS = 5'h1F;

    // First header word: payload length low, path id high
    typedef struct packed {
        logic [15:0] path;
        logic [15:0] len;
    } hdr_w0_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_READ,
        TX_LOAD,
        TX_SEND,
        TX_DONE
    } tx_state_e;

    // Total stream words for a payload length: two header words plus payload
    function automatic logic [16:0] pkt_words(input logic [15:0] len);
        return 17'd2 + ((17'(len) + 17'd3) >> 2);
    endfunction

endpackage

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
    parameter int unsigned WORDS = 1024,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    input  logic          b_re,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) begin
                mem[a_addr] <= a_wdata;
            end
            a_rdata <= mem[a_addr];
        end
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        if (b_re) begin
            b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/mbx_tx_engine.sv
module mbx_tx_engine
    import mbx_pkg::*;
#(
    parameter int unsigned BUF_WORDS = 1024,
    localparam int unsigned AW       = $clog2(BUF_WORDS),
    localparam int unsigned CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    output logic          done,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    input  logic [31:0]   ram_rdata,
    output logic          s_valid,
    input  logic          s_ready,
    output logic [31:0]   s_data,
    output logic          s_last
);

    localparam logic [15:0] MAX_LEN = 16'(BUF_WORDS * 4 - HDR_BYTES);

    tx_state_e     st_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] total_q;
    logic [31:0]   out_q;
    hdr_w0_t       hdr;

    assign hdr      = hdr_w0_t'(ram_rdata);
    assign ram_re   = (st_q == TX_READ);
    assign ram_addr = idx_q[AW-1:0];
    assign s_valid  = (st_q == TX_SEND);
    assign s_data   = out_q;
    assign s_last   = s_valid && (idx_q == total_q - CW'(1));
    assign done     = (st_q == TX_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= TX_IDLE;
            idx_q   <= '0;
            total_q <= '0;
            out_q   <= '0;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (busy) begin
                        idx_q <= '0;
                        st_q  <= TX_READ;
                    end
                end
                TX_READ: st_q <= TX_LOAD;
                TX_LOAD: begin
                    out_q <= ram_rdata;
                    if (idx_q == '0) begin
                        if (hdr.len > MAX_LEN) begin
                            st_q <= TX_DONE;
                        end else begin
                            total_q <= CW'(pkt_words(hdr.len));
                            st_q    <= TX_SEND;
                        end
                    end else begin
                        st_q <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (s_ready) begin
                        if (s_last) begin
                            st_q <= TX_DONE;
                        end else begin
                            idx_q <= idx_q + CW'(1);
                            st_q  <= TX_READ;
                        end
                    end
                end
                TX_DONE: st_q <= TX_IDLE;
                default: st_q <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbx_rx_engine.sv
module mbx_rx_engine
    import mbx_pkg::*;
#(
    parameter int unsigned BUF_WORDS = 1024,
    localparam int unsigned AW       = $clog2(BUF_WORDS),
    localparam int unsigned CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          full,
    output logic          done,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [31:0]   ram_wdata,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [31:0]   s_data,
    input  logic          s_last
);

    localparam logic [15:0] MAX_LEN = 16'(BUF_WORDS * 4 - HDR_BYTES);

    logic [CW-1:0] idx_q;
    logic          drop_q;
    logic          take;
    logic          bad_len;
    logic          over;
    logic          discard;
    hdr_w0_t       hdr;

    assign hdr       = hdr_w0_t'(s_data);
    assign s_ready   = !full;
    assign take      = s_valid && s_ready;
    assign bad_len   = (idx_q == '0) && (hdr.len > MAX_LEN);
    assign over      = (idx_q >= CW'(BUF_WORDS));
    assign discard   = drop_q || bad_len || over;
    assign ram_we    = take && !discard;
    assign ram_addr  = idx_q[AW-1:0];
    assign ram_wdata = s_data;
    assign done      = take && s_last && !discard;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            drop_q <= 1'b0;
        end else if (take) begin
            if (s_last) begin
                idx_q  <= '0;
                drop_q <= 1'b0;
            end else begin
                drop_q <= discard;
                if (!over) begin
                    idx_q <= idx_q + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter logic [31:0] VERSION   = 32'h0104_0141
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [4:0]           off,
    input  logic [31:0]          wdata,
    input  logic [NUM_PORTS-1:0] tx_done,
    input  logic [NUM_PORTS-1:0] rx_done,
    output logic [31:0]          rdata,
    output logic [NUM_PORTS-1:0] tx_busy,
    output logic [NUM_PORTS-1:0] rx_full,
    output logic                 irq
);

    logic [NUM_PORTS-1:0] busy_q, busy_d;
    logic [NUM_PORTS-1:0] full_q, full_d;
    logic                 ien_q;
    logic                 pend_q;
    logic                 evt;
    logic                 flag_wr;
    logic [31:0]          flag_word;

    assign flag_wr = wr_en && (off == OFF_FLAGS);

    always_comb begin
        busy_d = busy_q & ~tx_done;
        full_d = full_q;
        if (flag_wr) begin
            busy_d = busy_d | wdata[NUM_PORTS-1:0];
            full_d = full_d & ~wdata[FLAG_RX_BASE +: NUM_PORTS];
        end
        full_d = full_d | rx_done;
        evt    = (|(full_d & ~full_q)) || (|(busy_q & ~busy_d));
    end

    always_comb begin
        flag_word = '0;
        flag_word[NUM_PORTS-1:0] = busy_q;
        flag_word[FLAG_RX_BASE +: NUM_PORTS] = full_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            full_q <= '0;
            ien_q  <= 1'b0;
            pend_q <= 1'b0;
            rdata  <= '0;
        end else begin
            busy_q <= busy_d;
            full_q <= full_d;
            if (wr_en && off == OFF_IEN) begin
                ien_q <= wdata[0];
            end
            if (evt) begin
                pend_q <= 1'b1;
            end else if (wr_en && off == OFF_ICLR) begin
                pend_q <= 1'b0;
            end
            if (rd_en) begin
                case (off)
                    OFF_FLAGS: rdata <= flag_word;
                    OFF_IEN:   rdata <= {31'd0, ien_q};
                    OFF_VER:   rdata <= VERSION;
                    default:   rdata <= '0;
                endcase
            end
        end
    end

    assign tx_busy = busy_q;
    assign rx_full = full_q;
    assign irq     = pend_q && ien_q;

endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned BUF_BYTES = 4096,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd4,
    parameter logic [15:0] VER_BUILD = 16'd321,
    localparam int unsigned BUF_WORDS = BUF_BYTES / 4,
    localparam int unsigned BAW       = $clog2(BUF_WORDS),
    localparam int unsigned HA_W      = $clog2(BUF_BYTES * 2 * MAX_PORTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hst_req,
    input  logic                    hst_we,
    input  logic                    hst_space,
    input  logic [HA_W-1:0]         hst_addr,
    input  logic [31:0]             hst_wdata,
    output logic [31:0]             hst_rdata,
    output logic                    hst_rvalid,
    output logic                    irq,
    output logic [NUM_PORTS-1:0]    txs_valid,
    input  logic [NUM_PORTS-1:0]    txs_ready,
    output logic [NUM_PORTS*32-1:0] txs_data,
    output logic [NUM_PORTS-1:0]    txs_last,
    input  logic [NUM_PORTS-1:0]    rxs_valid,
    output logic [NUM_PORTS-1:0]    rxs_ready,
    input  logic [NUM_PORTS*32-1:0] rxs_data,
    input  logic [NUM_PORTS-1:0]    rxs_last
);

    logic [NUM_PORTS-1:0] tx_busy, rx_full, tx_done, rx_done;
    logic [31:0]          reg_rdata;
    logic [1:0]           port_sel;
    logic                 dir_tx;
    logic [BAW-1:0]       word_sel;
    logic [31:0]          rxa_rd [MAX_PORTS];
    logic [31:0]          txa_rd [MAX_PORTS];
    logic                 rvalid_q, rsp_q, rdir_q;
    logic [1:0]           rport_q;
    logic [1:0]           unused_addr_lsb;

    assign unused_addr_lsb = hst_addr[1:0];
    assign port_sel = hst_addr[HA_W-1 -: 2];
    assign dir_tx   = hst_addr[HA_W-3];
    assign word_sel = hst_addr[BAW+1:2];

    mbx_regs #(
        .NUM_PORTS (NUM_PORTS),
        .VERSION   ({VER_MAJOR, VER_MINOR, VER_BUILD})
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hst_req && hst_we && !hst_space),
        .rd_en   (hst_req && !hst_we && !hst_space),
        .off     (hst_addr[6:2]),
        .wdata   (hst_wdata),
        .tx_done (tx_done),
        .rx_done (rx_done),
        .rdata   (reg_rdata),
        .tx_busy (tx_busy),
        .rx_full (rx_full),
        .irq     (irq)
    );

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        if (p < NUM_PORTS) begin : g_on
            logic           sel;
            logic           tx_re;
            logic [BAW-1:0] tx_addr;
            logic [31:0]    tx_rd;
            logic           rx_we;
            logic [BAW-1:0] rx_addr;
            logic [31:0]    rx_wd;
            logic [31:0]    unused_rx_brd;

            assign sel = hst_req && hst_space && (port_sel == 2'(p));

            mbx_dpram #(.WORDS(BUF_WORDS)) u_rxbuf (
                .clk     (clk),
                .a_en    (sel && !dir_tx),
                .a_we    (hst_we),
                .a_addr  (word_sel),
                .a_wdata (hst_wdata),
                .a_rdata (rxa_rd[p]),
                .b_re    (1'b0),
                .b_we    (rx_we),
                .b_addr  (rx_addr),
                .b_wdata (rx_wd),
                .b_rdata (unused_rx_brd)
            );

            mbx_dpram #(.WORDS(BUF_WORDS)) u_txbuf (
                .clk     (clk),
                .a_en    (sel && dir_tx),
                .a_we    (hst_we),
                .a_addr  (word_sel),
                .a_wdata (hst_wdata),
                .a_rdata (txa_rd[p]),
                .b_re    (tx_re),
                .b_we    (1'b0),
                .b_addr  (tx_addr),
                .b_wdata (32'd0),
                .b_rdata (tx_rd)
            );

            mbx_tx_engine #(.BUF_WORDS(BUF_WORDS)) u_tx (
                .clk       (clk),
                .rst       (rst),
                .busy      (tx_busy[p]),
                .done      (tx_done[p]),
                .ram_re    (tx_re),
                .ram_addr  (tx_addr),
                .ram_rdata (tx_rd),
                .s_valid   (txs_valid[p]),
                .s_ready   (txs_ready[p]),
                .s_data    (txs_data[p*32 +: 32]),
                .s_last    (txs_last[p])
            );

            mbx_rx_engine #(.BUF_WORDS(BUF_WORDS)) u_rx (
                .clk       (clk),
                .rst       (rst),
                .full      (rx_full[p]),
                .done      (rx_done[p]),
                .ram_we    (rx_we),
                .ram_addr  (rx_addr),
                .ram_wdata (rx_wd),
                .s_valid   (rxs_valid[p]),
                .s_ready   (rxs_ready[p]),
                .s_data    (rxs_data[p*32 +: 32]),
                .s_last    (rxs_last[p])
            );
        end else begin : g_off
            assign rxa_rd[p] = '0;
            assign txa_rd[p] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rsp_q    <= 1'b0;
            rdir_q   <= 1'b0;
            rport_q  <= '0;
        end else begin
            rvalid_q <= hst_req && !hst_we;
            if (hst_req && !hst_we) begin
                rsp_q   <= hst_space;
                rdir_q  <= dir_tx;
                rport_q <= port_sel;
            end
        end
    end

    assign hst_rvalid = rvalid_q;
    assign hst_rdata  = !rsp_q ? reg_rdata :
                        (rdir_q ? txa_rd[rport_q] : rxa_rd[rport_q]);

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    hst_req,
    input logic                    hst_we,
    input logic                    hst_space,
    input logic [4:0]              hst_off,
    input logic                    hst_rvalid,
    input logic                    irq,
    input logic [NUM_PORTS-1:0]    tx_busy,
    input logic [NUM_PORTS-1:0]    rx_full,
    input logic [NUM_PORTS-1:0]    tx_done,
    input logic [NUM_PORTS-1:0]    txs_valid,
    input logic [NUM_PORTS-1:0]    txs_ready,
    input logic [NUM_PORTS*32-1:0] txs_data,
    input logic [NUM_PORTS-1:0]    txs_last,
    input logic [NUM_PORTS-1:0]    rxs_ready
);

    logic irq_keep_wr;
    assign irq_keep_wr = hst_req && hst_we && !hst_space &&
                         (hst_off == OFF_ICLR || hst_off == OFF_IEN);

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        hst_req && !hst_we |=> hst_rvalid);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_keep_wr |=> irq);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tx_busy == '0 && rx_full == '0 && !irq));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R5
        tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
            txs_valid[p] && !txs_ready[p] |=>
                txs_valid[p] && $stable(txs_data[p*32 +: 32]) && $stable(txs_last[p]));

        // R5
        tx_owner_chk: assert property (@(posedge clk) disable iff (rst)
            txs_valid[p] |-> tx_busy[p]);

        // R7
        rx_block_chk: assert property (@(posedge clk) disable iff (rst)
            rx_full[p] |-> !rxs_ready[p]);

        // R2
        busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(tx_busy[p]) |-> $past(tx_done[p]));
    end

endmodule

bind pkt_mailbox mbx_checker #(.NUM_PORTS(NUM_PORTS)) u_mbx_chk (
    .clk        (clk),
    .rst        (rst),
    .hst_req    (hst_req),
    .hst_we     (hst_we),
    .hst_space  (hst_space),
    .hst_off    (hst_addr[6:2]),
    .hst_rvalid (hst_rvalid),
    .irq        (irq),
    .tx_busy    (tx_busy),
    .rx_full    (rx_full),
    .tx_done    (tx_done),
    .txs_valid  (txs_valid),
    .txs_ready  (txs_ready),
    .txs_data   (txs_data),
    .txs_last   (txs_last),
    .rxs_ready  (rxs_ready)
);

// File: tb/tb_pkt_mailbox.sv
module tb_pkt_mailbox;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          hst_req, hst_we, hst_space;
    logic [14:0]   hst_addr;
    logic [31:0]   hst_wdata, hst_rdata;
    logic          hst_rvalid, irq;
    logic [NP-1:0] txs_valid, txs_ready, txs_last;
    logic [NP*32-1:0] txs_data;
    logic [NP-1:0] rxs_valid, rxs_ready, rxs_last;
    logic [NP*32-1:0] rxs_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] got [0:1099];

    always #4 clk = ~clk;

    pkt_mailbox #(.NUM_PORTS(NP)) dut (
        .clk(clk), .rst(rst),
        .hst_req(hst_req), .hst_we(hst_we), .hst_space(hst_space),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .irq(irq),
        .txs_valid(txs_valid), .txs_ready(txs_ready),
        .txs_data(txs_data), .txs_last(txs_last),
        .rxs_valid(rxs_valid), .rxs_ready(rxs_ready),
        .rxs_data(rxs_data), .rxs_last(rxs_last)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        wr;
        logic        sp;
        logic [14:0] ad;
        logic [31:0] dt;
    } vec_t;

    localparam vec_t VECS [17] = '{
        '{4'd1, 1'b0, 1'b0, 15'h0074, 32'h0104_0141}, // R1 version
        '{4'd1, 1'b1, 1'b0, 15'h0074, 32'hFFFF_FFFF},
        '{4'd1, 1'b0, 1'b0, 15'h0074, 32'h0104_0141}, // R1 read-only
        '{4'd1, 1'b1, 1'b0, 15'h0078, 32'h0000_0001},
        '{4'd1, 1'b0, 1'b0, 15'h0078, 32'h0000_0001}, // R1 enable
        '{4'd1, 1'b1, 1'b0, 15'h0078, 32'h0000_0000},
        '{4'd1, 1'b0, 1'b0, 15'h0078, 32'h0000_0000},
        '{4'd1, 1'b0, 1'b0, 15'h0010, 32'h0000_0000}, // R1 unmapped
        '{4'd4, 1'b1, 1'b1, 15'h1014, 32'hA5A5_0001},
        '{4'd4, 1'b0, 1'b1, 15'h1014, 32'hA5A5_0001}, // R4 port0 tx
        '{4'd4, 1'b1, 1'b1, 15'h300C, 32'h5A5A_0002},
        '{4'd4, 1'b1, 1'b1, 15'h100C, 32'h0BAD_F00D},
        '{4'd4, 1'b0, 1'b1, 15'h300C, 32'h5A5A_0002}, // R4 port1 tx
        '{4'd4, 1'b1, 1'b1, 15'h001C, 32'h1234_5678},
        '{4'd4, 1'b0, 1'b1, 15'h001C, 32'h1234_5678}, // R4 port0 rx
        '{4'd4, 1'b1, 1'b1, 15'h5000, 32'hDEAD_BEEF},
        '{4'd4, 1'b0, 1'b1, 15'h5000, 32'h0000_0000}  // R4 inactive port
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic sp, input logic [14:0] ad, input logic [31:0] dt);
        hst_req = 1; hst_we = 1; hst_space = sp; hst_addr = ad; hst_wdata = dt;
        @(negedge clk);
        hst_req = 0; hst_we = 0;
    endtask

    task automatic bus_rd(input logic sp, input logic [14:0] ad, output logic [31:0] dt);
        hst_req = 1; hst_we = 0; hst_space = sp; hst_addr = ad;
        @(negedge clk);
        hst_req = 0;
        dt = hst_rdata;
    endtask

    task automatic wait_flags(input logic [31:0] exp, input string rq);
        logic [31:0] v;
        v = 32'hx;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(0, 15'h007C, v);
            if (v == exp) break;
        end
        chk(rq, v, exp);
    endtask

    task automatic tx_collect(input int p, input int rmod, output int n);
        bit fin;
        fin = 0; n = 0;
        for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
            txs_ready[p] = ((cyc % rmod) == 0);
            #1;
            if (txs_valid[p] && txs_ready[p]) begin
                got[n] = txs_data[p*32 +: 32];
                n++;
                if (txs_last[p]) fin = 1;
            end
            @(negedge clk);
        end
        txs_ready[p] = 0;
    endtask

    task automatic rx_word(input int p, input logic [31:0] d, input logic lst);
        rxs_valid[p] = 1; rxs_data[p*32 +: 32] = d; rxs_last[p] = lst;
        for (int i = 0; i < 100 && !rxs_ready[p]; i++) @(negedge clk);
        @(negedge clk);
        rxs_valid[p] = 0; rxs_last[p] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        int n;
        int seen;
        rst = 1; hst_req = 0; hst_we = 0; hst_space = 0; hst_addr = '0; hst_wdata = '0;
        txs_ready = '0; rxs_valid = '0; rxs_last = '0; rxs_data = '0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R11 reset state
        bus_rd(0, 15'h007C, v); chk("R11 flags", v, 0);
        bus_rd(0, 15'h0078, v); chk("R11 ien", v, 0);
        chk("R11 irq", {31'd0, irq}, 0);

        foreach (VECS[i]) begin
            if (VECS[i].wr) bus_wr(VECS[i].sp, VECS[i].ad, VECS[i].dt);
            else begin
                bus_rd(VECS[i].sp, VECS[i].ad, v);
                chk($sformatf("R%0d vec%0d", VECS[i].rq, i), v, VECS[i].dt);
            end
        end

        // R2 inactive port bits ignored
        bus_wr(0, 15'h007C, 32'h0000_00CC);
        bus_rd(0, 15'h007C, v); chk("R2 inactive", v, 0);

        // R5 port0 packet len 10 -> 5 words
        bus_wr(0, 15'h0078, 1);
        bus_wr(1, 15'h1000, 32'h0012_000A);
        bus_wr(1, 15'h1004, 32'h0000_0020);
        for (int i = 0; i < 3; i++) bus_wr(1, 15'(32'h1008 + 4*i), 32'hB000_0000 + i);
        bus_wr(0, 15'h007C, 32'h1);
        tx_collect(0, 1, n);
        chk("R5 count", n, 5);
        chk("R5 hdr0", got[0], 32'h0012_000A);
        chk("R5 hdr1", got[1], 32'h0000_0020);
        chk("R5 pay2", got[4], 32'hB000_0002);
        wait_flags(0, "R5 busy clears");
        chk("R9 irq after tx", {31'd0, irq}, 1);
        bus_wr(0, 15'h0070, 0);
        chk("R10 clear", {31'd0, irq}, 0);

        // R2 write 0 keeps busy; R5 backpressure on port1 len 5 -> 4 words
        bus_wr(1, 15'h3000, 32'h0001_0005);
        bus_wr(1, 15'h3004, 32'h0001_0033);
        bus_wr(1, 15'h3008, 32'hC100_0000);
        bus_wr(1, 15'h300C, 32'hC100_0001);
        bus_wr(0, 15'h007C, 32'h2);
        bus_wr(0, 15'h007C, 32'h0);
        bus_rd(0, 15'h007C, v); chk("R2 zero write", v, 32'h2);
        tx_collect(1, 3, n);
        chk("R5 backpressure count", n, 4);
        chk("R5 backpressure last", got[3], 32'hC100_0001);
        wait_flags(0, "R5 port1 busy clears");
        chk("R10 event relatch", {31'd0, irq}, 1);
        bus_wr(0, 15'h0070, 0);

        // R5 maximum payload 4088 -> 1024 words
        bus_wr(1, 15'h1000, 32'h0000_0FF8);
        for (int i = 0; i < 1022; i++) bus_wr(1, 15'(32'h1008 + 4*i), 32'hD000_0000 + i);
        bus_wr(0, 15'h007C, 32'h1);
        tx_collect(0, 1, n);
        chk("R5 max count", n, 1024);
        chk("R5 max last", got[1023], 32'hD000_03FD);
        wait_flags(0, "R5 max busy clears");

        // R6 oversize transmit
        bus_wr(1, 15'h1000, 32'h0000_0FF9);
        bus_wr(0, 15'h007C, 32'h1);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (txs_valid[0]) seen++;
            @(negedge clk);
        end
        chk("R6 no words", seen, 0);
        bus_rd(0, 15'h007C, v); chk("R6 busy clears", v, 0);
        bus_wr(0, 15'h0070, 0);

        // R7 receive on port0: len 6 -> 4 words
        rx_word(0, 32'h0003_0006, 0);
        rx_word(0, 32'h0001_0040, 0);
        rx_word(0, 32'hE000_0000, 0);
        rx_word(0, 32'hE000_0001, 1);
        bus_rd(0, 15'h007C, v); chk("R7 ready set", v, 32'h10);
        bus_rd(1, 15'h0000, v); chk("R7 word0", v, 32'h0003_0006);
        bus_rd(1, 15'h000C, v); chk("R7 word3", v, 32'hE000_0001);
        chk("R7 blocked", {31'd0, rxs_ready[0]}, 0);
        chk("R9 irq after rx", {31'd0, irq}, 1);
        bus_wr(0, 15'h0070, 0);
        bus_wr(0, 15'h007C, 32'h0);
        bus_rd(0, 15'h007C, v); chk("R3 zero write", v, 32'h10);
        bus_wr(0, 15'h007C, 32'h10);
        bus_rd(0, 15'h007C, v); chk("R3 release", v, 0);
        chk("R3 ready again", {31'd0, rxs_ready[0]}, 1);

        // R8 oversize header discarded, next packet accepted
        rx_word(0, 32'h0000_1388, 0);
        rx_word(0, 32'hF000_0000, 1);
        bus_rd(0, 15'h007C, v); chk("R8 oversize dropped", v, 0);
        for (int i = 0; i < 1025; i++) rx_word(0, (i == 0) ? 32'h0000_0008 : 32'hF100_0000 + i, i == 1024);
        bus_rd(0, 15'h007C, v); chk("R8 overrun dropped", v, 0);
        rx_word(0, 32'h0000_0000, 0);
        rx_word(0, 32'h0005_0077, 1);
        bus_rd(0, 15'h007C, v); chk("R8 recovers", v, 32'h10);
        bus_rd(1, 15'h0004, v); chk("R8 new word1", v, 32'h0005_0077);
        bus_wr(0, 15'h007C, 32'h10);
        bus_wr(0, 15'h0070, 0);

        // R9 masking keeps pending
        bus_wr(0, 15'h0078, 0);
        rx_word(1, 32'h0000_0000, 0);
        rx_word(1, 32'h0000_0001, 1);
        @(negedge clk);
        chk("R9 masked", {31'd0, irq}, 0);
        bus_wr(0, 15'h0078, 1);
        chk("R9 unmask pending", {31'd0, irq}, 1);
        bus_rd(0, 15'h007C, v); chk("R7 port1 ready", v, 32'h20);

        summary();
    end

endmodule